// File: doc/BRIEF.md
# Gate Input Coverage Histogram

This block watches the three inputs of one logic gate and records how often each of the eight possible input combinations is present at a clock edge. The three observed bits form an index from 0 to 7 that selects one counter. Sampling happens only at the rising clock edge, so glitches that settle within a cycle are never recorded. Counting runs while the run-enable is high. Each counter stops at a parameterised ceiling and does not roll over.

When a done strobe arrives, the counters freeze and the block sorts the eight bins by count. It then offers them on a valid/ready port, smallest count first, so the least exercised combinations appear at the head of the list. A combination that never occurred carries a null flag that marks it as unexercised, which is different from being merely rare. A synchronous reset clears the histogram and returns the block to counting.

Top module: `combo_cov_monitor`

## Requirements
- R1: While counting and `run_en` is high, each rising edge adds one to exactly one bin: the bin whose number equals `obs` read as an unsigned value (`obs[2]` is the most significant bit).
- R2: A clock edge with `run_en` low changes no bin.
- R3: A bin that holds `CNT_MAX` (default 255) stays at `CNT_MAX` when it is hit again.
- R4: The edge that samples `done` high does not count the current `obs`. After that edge, no activity on `obs`, `run_en` or `done` changes any bin until reset.
- R5: The readout gives all eight bins exactly once, in ascending order of count. Bins with equal counts appear in ascending order of bin number.
- R6: `out_null` is high exactly when the presented entry's count is zero.
- R7: Each rising edge with `out_valid` and `out_ready` both high consumes one entry. While `out_valid` is high and `out_ready` is low, `out_bin`, `out_count` and `out_last` hold their values.
- R8: `out_last` is high only on the eighth entry. Once that entry is accepted, `out_valid` stays low until reset.
- R9: A synchronous `rst` clears every bin, drops `out_valid` on the following cycle and returns the block to counting, even in the middle of a readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| obs | input | 3 | Observed gate inputs, taken as the bin number |
| run_en | input | 1 | Count enable during the run |
| done | input | 1 | End-of-run strobe: freezes the bins and starts the sort |
| out_ready | input | 1 | Consumer accepts the presented entry |
| out_valid | output | 1 | A readout entry is presented |
| out_bin | output | 3 | Bin number of the presented entry |
| out_count | output | CNT_W | Count of the presented entry |
| out_null | output | 1 | Presented bin was never exercised |
| out_last | output | 1 | Presented entry is the eighth one |

## Verification
On every cycle, the assertions check that no more than one bin's increment enable is active and that no increment fires while an entry is presented. They also check that a stalled entry stays still, that each accepted entry is followed by one with a larger key (count, then bin number), and that the port goes quiet after the last entry and after reset. The count values themselves can only be shown by the bench scenarios, which compare them against a reference histogram: the exact totals, saturation at the ceiling, the uncounted sample on the done edge, the ignored cycles with run-enable low, tie ordering and null flags.

// File: rtl/cov_pkg.sv
package cov_pkg;

  typedef enum logic [1:0] {
    ST_COUNT,
    ST_SORT,
    ST_READ,
    ST_HOLD
  } cov_state_e;

  // Saturating increment: stays at lim once reached.
  function automatic logic [31:0] sat_inc(input logic [31:0] c, input logic [31:0] lim);
    return (c >= lim) ? c : c + 32'd1;
  endfunction

  // True when key (ca, ia) must be placed after key (cb, ib).
  function automatic logic key_after(input logic [31:0] ca, input logic [31:0] ia,
                                     input logic [31:0] cb, input logic [31:0] ib);
    return (ca > cb) || ((ca == cb) && (ia > ib));
  endfunction

endpackage

// File: rtl/cov_bin_bank.sv
module cov_bin_bank #(
  parameter int NUM_BINS = 8,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 8,
  parameter int CNT_MAX  = 255
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sample_en,
  input  logic [IDX_W-1:0]          sample_idx,
  output logic [NUM_BINS-1:0]       inc_vec,
  output logic [NUM_BINS*CNT_W-1:0] bins_flat
);

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    logic [CNT_W-1:0] cnt_q;

    assign inc_vec[b] = sample_en && (sample_idx == IDX_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else if (inc_vec[b]) begin
        cnt_q <= CNT_W'(cov_pkg::sat_inc(32'(cnt_q), 32'(CNT_MAX)));
      end
    end

    assign bins_flat[b*CNT_W +: CNT_W] = cnt_q;
  end

endmodule

// File: rtl/cov_sort_net.sv
module cov_sort_net #(
  parameter int NUM_BINS = 8,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic                      step,
  input  logic                      phase,
  input  logic [NUM_BINS*CNT_W-1:0] bins_flat,
  output logic [NUM_BINS*CNT_W-1:0] ent_cnt_flat,
  output logic [NUM_BINS*IDX_W-1:0] ent_idx_flat
);

  logic [CNT_W-1:0] cnt_q [NUM_BINS];
  logic [IDX_W-1:0] idx_q [NUM_BINS];
  logic [CNT_W-1:0] cnt_n [NUM_BINS];
  logic [IDX_W-1:0] idx_n [NUM_BINS];

  // One odd-even transposition pass: phase picks the pairs (0,1),(2,3).. or (1,2),(3,4)..
  always_comb begin
    for (int i = 0; i < NUM_BINS; i++) begin
      cnt_n[i] = cnt_q[i];
      idx_n[i] = idx_q[i];
    end
    for (int i = 0; i + 1 < NUM_BINS; i++) begin
      if ((i[0] == phase) &&
          cov_pkg::key_after(32'(cnt_q[i]), 32'(idx_q[i]),
                             32'(cnt_q[i+1]), 32'(idx_q[i+1]))) begin
        cnt_n[i]   = cnt_q[i+1];
        idx_n[i]   = idx_q[i+1];
        cnt_n[i+1] = cnt_q[i];
        idx_n[i+1] = idx_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BINS; i++) begin
      if (rst) begin
        cnt_q[i] <= '0;
        idx_q[i] <= IDX_W'(i);
      end else if (load) begin
        cnt_q[i] <= bins_flat[i*CNT_W +: CNT_W];
        idx_q[i] <= IDX_W'(i);
      end else if (step) begin
        cnt_q[i] <= cnt_n[i];
        idx_q[i] <= idx_n[i];
      end
    end
  end

  for (genvar e = 0; e < NUM_BINS; e++) begin : g_flat
    assign ent_cnt_flat[e*CNT_W +: CNT_W] = cnt_q[e];
    assign ent_idx_flat[e*IDX_W +: IDX_W] = idx_q[e];
  end

endmodule

// File: rtl/cov_readout.sv
module cov_readout #(
  parameter int NUM_BINS = 8,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      active,
  input  logic [NUM_BINS*CNT_W-1:0] ent_cnt_flat,
  input  logic [NUM_BINS*IDX_W-1:0] ent_idx_flat,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [IDX_W-1:0]          out_bin,
  output logic [CNT_W-1:0]          out_count,
  output logic                      out_null,
  output logic                      out_last,
  output logic                      drained
);

  localparam int PTR_W = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_arr [NUM_BINS];
  logic [IDX_W-1:0] idx_arr [NUM_BINS];
  logic             accept;

  for (genvar e = 0; e < NUM_BINS; e++) begin : g_unpack
    assign cnt_arr[e] = ent_cnt_flat[e*CNT_W +: CNT_W];
    assign idx_arr[e] = ent_idx_flat[e*IDX_W +: IDX_W];
  end

  assign out_valid = active;
  assign out_count = cnt_arr[ptr_q];
  assign out_bin   = idx_arr[ptr_q];
  assign out_null  = (cnt_arr[ptr_q] == '0);
  assign out_last  = (ptr_q == PTR_W'(NUM_BINS - 1));
  assign accept    = active && out_ready;
  assign drained   = accept && out_last;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      ptr_q <= '0;
    end else if (accept) begin
      ptr_q <= out_last ? '0 : ptr_q + PTR_W'(1);
    end
  end

endmodule

// File: rtl/combo_cov_monitor.sv
module combo_cov_monitor #(
  parameter int IN_W    = 3,
  parameter int CNT_MAX = 255,
  localparam int NUM_BINS = 1 << IN_W,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  obs,
  input  logic             run_en,
  input  logic             done,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [IN_W-1:0]  out_bin,
  output logic [CNT_W-1:0] out_count,
  output logic             out_null,
  output logic             out_last
);

  import cov_pkg::*;

  localparam int PASS_W = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1;

  cov_state_e                state_q;
  logic [PASS_W-1:0]         pass_q;

  // Named internal events, brought out for the checker.
  logic                      counting;
  logic                      sample_en;
  logic                      sort_load;
  logic                      sort_step;
  logic                      sort_last;
  logic                      drained;
  logic [NUM_BINS-1:0]       inc_vec;
  logic [NUM_BINS*CNT_W-1:0] bins_flat;
  logic [NUM_BINS*CNT_W-1:0] ent_cnt_flat;
  logic [NUM_BINS*IN_W-1:0]  ent_idx_flat;

  assign counting  = (state_q == ST_COUNT);
  assign sample_en = counting && run_en && !done;
  assign sort_load = counting && done;
  assign sort_step = (state_q == ST_SORT);
  assign sort_last = sort_step && (pass_q == PASS_W'(NUM_BINS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_COUNT;
      pass_q  <= '0;
    end else begin
      unique case (state_q)
        ST_COUNT: begin
          pass_q <= '0;
          if (done) state_q <= ST_SORT;
        end
        ST_SORT: begin
          pass_q <= pass_q + PASS_W'(1);
          if (sort_last) state_q <= ST_READ;
        end
        ST_READ: begin
          if (drained) state_q <= ST_HOLD;
        end
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  cov_bin_bank #(
    .NUM_BINS(NUM_BINS), .IDX_W(IN_W), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)
  ) u_bank (
    .clk(clk), .rst(rst), .sample_en(sample_en), .sample_idx(obs),
    .inc_vec(inc_vec), .bins_flat(bins_flat)
  );

  cov_sort_net #(
    .NUM_BINS(NUM_BINS), .IDX_W(IN_W), .CNT_W(CNT_W)
  ) u_sort (
    .clk(clk), .rst(rst), .load(sort_load), .step(sort_step), .phase(pass_q[0]),
    .bins_flat(bins_flat), .ent_cnt_flat(ent_cnt_flat), .ent_idx_flat(ent_idx_flat)
  );

  cov_readout #(
    .NUM_BINS(NUM_BINS), .IDX_W(IN_W), .CNT_W(CNT_W)
  ) u_read (
    .clk(clk), .rst(rst), .active(state_q == ST_READ),
    .ent_cnt_flat(ent_cnt_flat), .ent_idx_flat(ent_idx_flat),
    .out_ready(out_ready), .out_valid(out_valid), .out_bin(out_bin),
    .out_count(out_count), .out_null(out_null), .out_last(out_last),
    .drained(drained)
  );

endmodule

// File: rtl/cov_monitor_checker.sv
module cov_monitor_checker #(
  parameter int NUM_BINS = 8,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_BINS-1:0] inc_vec,
  input logic                out_valid,
  input logic                out_ready,
  input logic [IDX_W-1:0]    out_bin,
  input logic [CNT_W-1:0]    out_count,
  input logic                out_last
);

  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inc_vec));

  assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inc_vec == '0));

  assert_order_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && ((out_count > $past(out_count)) ||
                     ((out_count == $past(out_count)) && (out_bin > $past(out_bin))))));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_bin) && $stable(out_count) && $stable(out_last)));

  assert_last_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind combo_cov_monitor cov_monitor_checker #(
  .NUM_BINS(NUM_BINS), .IDX_W(IN_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .inc_vec(inc_vec), .out_valid(out_valid),
  .out_ready(out_ready), .out_bin(out_bin), .out_count(out_count),
  .out_last(out_last)
);

// File: tb/tb_combo_cov_monitor.sv
module tb_combo_cov_monitor;

  localparam int CMAX = 255;
  localparam int NB   = 8;

  // Stimulus table: {obs value, cycles, run_en}
  localparam int STIM [0:6][0:2] = '{
    '{3, 5, 1}, '{0, 2, 1}, '{7, 9, 1}, '{5, 4, 0},
    '{1, 2, 1}, '{6, 2, 1}, '{3, 3, 1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] obs = '0;
  logic       run_en = 1'b0;
  logic       done = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [2:0] out_bin;
  logic [7:0] out_count;
  logic       out_null;
  logic       out_last;

  int checks = 0;
  int fails  = 0;
  int hist [NB];

  always #4ns clk = ~clk;

  combo_cov_monitor #(.IN_W(3), .CNT_MAX(CMAX)) dut (
    .clk(clk), .rst(rst), .obs(obs), .run_en(run_en), .done(done),
    .out_ready(out_ready), .out_valid(out_valid), .out_bin(out_bin),
    .out_count(out_count), .out_null(out_null), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; run_en = 1'b0; done = 1'b0; out_ready = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < NB; b++) hist[b] = 0;
  endtask

  task automatic run(input int v, input int n, input bit en);
    for (int c = 0; c < n; c++) begin
      obs = 3'(v); run_en = en;
      @(negedge clk);
      if (en && hist[v] < CMAX) hist[v]++;
    end
    run_en = 1'b0;
  endtask

  // Done strobe with a sample that must not count, then activity that must be ignored (R4).
  task automatic end_run();
    obs = 3'd2; run_en = 1'b1; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    for (int c = 0; c < 12; c++) begin
      obs = obs + 3'd1; done = c[0];
      @(negedge clk);
    end
    run_en = 1'b0; done = 1'b0;
  endtask

  task automatic drain(input string tag);
    int  exp_bin [NB];
    bit  used [NB];
    for (int b = 0; b < NB; b++) used[b] = 1'b0;
    for (int k = 0; k < NB; k++) begin
      int best = -1;
      for (int b = 0; b < NB; b++)
        if (!used[b] && (best < 0 || hist[b] < hist[best])) best = b;
      exp_bin[k] = best;
      used[best] = 1'b1;
    end
    out_ready = 1'b0;
    for (int t = 0; t < 40 && !out_valid; t++) @(negedge clk);
    for (int k = 0; k < NB; k++) begin
      chk(out_valid === 1'b1, {tag, " R7 valid"}, int'(out_valid), 1);
      chk(out_bin == 3'(exp_bin[k]), {tag, " R5 bin order"}, int'(out_bin), exp_bin[k]);
      chk(int'(out_count) == hist[exp_bin[k]], {tag, " R1/R3 count"},
          int'(out_count), hist[exp_bin[k]]);
      chk(out_null == (hist[exp_bin[k]] == 0), {tag, " R6 null flag"},
          int'(out_null), int'(hist[exp_bin[k]] == 0));
      chk(out_last == (k == NB - 1), {tag, " R8 last flag"}, int'(out_last), int'(k == NB - 1));
      if (k % 3 == 0) begin
        @(negedge clk);
        chk(out_valid && out_bin == 3'(exp_bin[k]), {tag, " R7 stall hold"},
            int'(out_bin), exp_bin[k]);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(out_valid == 1'b0, {tag, " R8 valid after last"}, int'(out_valid), 0);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, {tag, " R8 stays idle"}, int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk(out_valid == 1'b0, "R9 reset state", int'(out_valid), 0);

    // Table walk: mixed patterns, a run_en-low stretch, ties at count 2 and 0.
    for (int s = 0; s < 7; s++) run(STIM[s][0], STIM[s][1], STIM[s][2] != 0);
    end_run();
    drain("R2 R4 table");

    // Saturation: one bin pushed past the ceiling, one exactly at it, one just below.
    do_reset();
    run(4, 300, 1'b1);
    run(2, CMAX, 1'b1);
    run(1, CMAX - 1, 1'b1);
    end_run();
    drain("R3 saturation");

    // Reset in the middle of a readout.
    do_reset();
    run(5, 3, 1'b1);
    end_run();
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid drops after reset", int'(out_valid), 0);
    do_reset();
    run(6, 1, 1'b1);
    end_run();
    drain("R9 after mid-read reset");

    // Empty run: every bin null, index order.
    do_reset();
    end_run();
    drain("R6 R9 empty");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule